// File: doc/BRIEF.md
# Multimode Serial Transmitter

This block turns a byte written by the host into a serial bit stream, in one of four frame formats chosen by a two-bit mode input. One format is a synchronous shift-out. It drives eight data bits on the data line and drives a separate shift clock. The other three are asynchronous frames on the same data line. One sends eight data bits. Two send nine data bits, where the ninth bit comes from a control input. In the fixed-rate formats the bit rate comes from internal dividers of the system clock. In the variable-rate formats it comes from an external rate tick, which is generated by a separate baud timer.

A write to the data input starts a frame when the block is idle, and the block raises busy until the frame ends. A sticky done flag marks the point where software may write the next byte. In the shift mode this point is the end of the eighth bit. In the asynchronous modes it is the start of the stop bit. The flag stays set until the clear strobe is pulsed.

Top module: `multimode_serial_tx`

## Requirements
- R1: Mode 01 sends a 10-bit frame: a low start bit, eight data bits least significant first, then a high stop bit. Modes 10 and 11 send an 11-bit frame, with the ninth-bit input value captured at the accepted write placed between the data and the stop bit. Outside a frame the line and the shift clock are high.
- R2: Mode 00 drives the eight data bits least significant first, each for 12 clock cycles. The shift clock is low for the first 6 cycles of each bit and high for the last 6. In the other modes the shift clock stays high.
- R3: In mode 10 each bit lasts 32 cycles when the rate-select input is 1 and 64 cycles when it is 0.
- R4: In modes 01 and 11 the start bit runs from the cycle after the accepted write until the first rate tick that follows. Each later bit ends on the next rate tick.
- R5: In mode 00 the done flag becomes 1 in the same cycle that busy falls after the eighth bit.
- R6: In modes 01, 10 and 11 the done flag becomes 1 in the cycle the line changes to the stop bit. The stop bit then lasts one full bit time before busy falls.
- R7: The done flag stays set until the clear strobe is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R8: A write while busy is 0 sets busy and drives the first bit from the next cycle. A write while busy is 1 is ignored: the current frame is unchanged and no second frame follows.
- R9: The mode and rate-select inputs are captured at the accepted write. Changing them during a frame does not alter that frame.
- R10: After reset the line is high, the shift clock is high, busy is 0 and the done flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Frame format select |
| rate_fast | input | 1 | Divider select for fixed-rate 9-bit mode (1 = /32) |
| rate_tick | input | 1 | One-cycle bit-rate pulse for the variable-rate modes |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Byte to send |
| ninth_bit | input | 1 | Extra data bit for 9-bit frames |
| done_clr | input | 1 | Clear strobe for the done flag |
| txd | output | 1 | Serial data line |
| shclk | output | 1 | Shift clock for mode 00 |
| busy | output | 1 | Frame in progress |
| done_flag | output | 1 | Sticky transmit-done flag |

## Verification
The bench attacks the point where the done flag rises, because it differs by format. A design that sets it at the end of the stop bit in the asynchronous modes, or one cycle early or late in the shift mode, misses the exact-cycle check. For every bit of every frame, bit lengths are measured at both the first and the last cycle of the bit. A divider that is off by one, or a wrong choice between /32 and /64, therefore shows up as a changed bit. While a frame is running, the bench issues a second write with different data, ninth bit, mode and rate select. A design that accepts the write, or that reads the mode live instead of capturing it, sends a corrupted frame or an extra one. Holding the clear strobe through the set cycle exposes a clear that wrongly takes priority.

// File: rtl/sptx_pkg.sv
package sptx_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT        = 2'b00,
    MODE_ASYNC8       = 2'b01,
    MODE_ASYNC9_FIXED = 2'b10,
    MODE_ASYNC9_TICK  = 2'b11
  } sptx_mode_e;

  // Bit boundaries come from the external tick rather than an internal divider
  function automatic logic uses_ext_tick(sptx_mode_e m);
    return (m == MODE_ASYNC8) || (m == MODE_ASYNC9_TICK);
  endfunction

  function automatic logic is_async(sptx_mode_e m);
    return m != MODE_SHIFT;
  endfunction

endpackage

// File: rtl/sptx_bit_timer.sv
module sptx_bit_timer
  import sptx_pkg::*;
#(
  parameter int SHIFT_DIV = 12,
  parameter int FAST_DIV  = 32,
  parameter int SLOW_DIV  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  sptx_mode_e load_mode,
  input  logic       busy,
  input  sptx_mode_e mode,
  input  logic       fast,
  input  logic       rate_tick,
  input  logic       frame_last,
  output logic       bit_end,
  output logic       shclk
);

  localparam int MAX_A   = (SHIFT_DIV > FAST_DIV) ? SHIFT_DIV : FAST_DIV;
  localparam int MAX_DIV = (MAX_A > SLOW_DIV) ? MAX_A : SLOW_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam int HALF    = SHIFT_DIV / 2;

  logic [CNT_W-1:0] cnt, cnt_nxt, lim;

  always_comb begin
    case (mode)
      MODE_SHIFT:        lim = CNT_W'(SHIFT_DIV - 1);
      MODE_ASYNC9_FIXED: lim = fast ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
      default:           lim = '0;
    endcase
  end

  assign bit_end = busy && (uses_ext_tick(mode) ? rate_tick : (cnt == lim));
  assign cnt_nxt = bit_end ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      shclk <= 1'b1;
    end else if (load) begin
      cnt   <= '0;
      shclk <= (load_mode != MODE_SHIFT);
    end else if (busy) begin
      cnt <= cnt_nxt;
      if (bit_end && frame_last)
        shclk <= 1'b1;
      else if (mode == MODE_SHIFT)
        shclk <= (cnt_nxt >= CNT_W'(HALF));
    end
  end

endmodule

// File: rtl/sptx_frame_shifter.sv
module sptx_frame_shifter
  import sptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  sptx_mode_e        load_mode,
  input  logic              load_fast,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_ninth,
  input  logic              bit_end,
  output logic              busy,
  output logic              txd,
  output sptx_mode_e        mode_q,
  output logic              fast_q,
  output logic              frame_last,
  output logic              done_set
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_SHIFT = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_A8    = IDX_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST_A9    = IDX_W'(DATA_W + 2);

  logic [FRAME_W-1:0] frame_in;
  logic [FRAME_W-2:0] rest;
  logic [IDX_W-1:0]   idx, last_idx, last_in;
  logic               stop_entry, shift_end;

  // Assemble the whole frame, first bit in position 0
  always_comb begin
    case (load_mode)
      MODE_SHIFT:  begin frame_in = {3'b111, load_data};                 last_in = LAST_SHIFT; end
      MODE_ASYNC8: begin frame_in = {2'b11, load_data, 1'b0};            last_in = LAST_A8;    end
      default:     begin frame_in = {1'b1, load_ninth, load_data, 1'b0}; last_in = LAST_A9;    end
    endcase
  end

  assign frame_last = busy && (idx == last_idx);
  assign stop_entry = bit_end && is_async(mode_q) && (idx == last_idx - 1'b1);
  assign shift_end  = bit_end && (mode_q == MODE_SHIFT) && frame_last;
  assign done_set   = stop_entry || shift_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      txd      <= 1'b1;
      rest     <= '1;
      idx      <= '0;
      last_idx <= '0;
      mode_q   <= MODE_SHIFT;
      fast_q   <= 1'b0;
    end else if (load) begin
      busy     <= 1'b1;
      txd      <= frame_in[0];
      rest     <= frame_in[FRAME_W-1:1];
      idx      <= '0;
      last_idx <= last_in;
      mode_q   <= load_mode;
      fast_q   <= load_fast;
    end else if (bit_end) begin
      if (frame_last) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        txd  <= rest[0];
        rest <= {1'b1, rest[FRAME_W-2:1]};
        idx  <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sptx_done_flag.sv
module sptx_done_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic clr_pulse,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)            flag <= 1'b0;
    else if (set_pulse) flag <= 1'b1;
    else if (clr_pulse) flag <= 1'b0;
  end

endmodule

// File: rtl/multimode_serial_tx.sv
module multimode_serial_tx
  import sptx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SHIFT_DIV = 12,
  parameter int FAST_DIV  = 32,
  parameter int SLOW_DIV  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              rate_fast,
  input  logic              rate_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ninth_bit,
  input  logic              done_clr,
  output logic              txd,
  output logic              shclk,
  output logic              busy,
  output logic              done_flag
);

  sptx_mode_e mode_in, mode_q;
  logic       load, bit_end, frame_last, done_set, fast_q;

  assign mode_in = sptx_mode_e'(mode_sel);
  assign load    = wr_en && !busy;

  sptx_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_mode  (mode_in),
    .load_fast  (rate_fast),
    .load_data  (wr_data),
    .load_ninth (ninth_bit),
    .bit_end    (bit_end),
    .busy       (busy),
    .txd        (txd),
    .mode_q     (mode_q),
    .fast_q     (fast_q),
    .frame_last (frame_last),
    .done_set   (done_set)
  );

  sptx_bit_timer #(
    .SHIFT_DIV (SHIFT_DIV),
    .FAST_DIV  (FAST_DIV),
    .SLOW_DIV  (SLOW_DIV)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_mode  (mode_in),
    .busy       (busy),
    .mode       (mode_q),
    .fast       (fast_q),
    .rate_tick  (rate_tick),
    .frame_last (frame_last),
    .bit_end    (bit_end),
    .shclk      (shclk)
  );

  sptx_done_flag u_flag (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (done_set),
    .clr_pulse (done_clr),
    .flag      (done_flag)
  );

endmodule

// File: rtl/sptx_checker.sv
module sptx_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_sel,
  input logic       wr_en,
  input logic       done_clr,
  input logic       txd,
  input logic       shclk,
  input logic       busy,
  input logic       done_flag,
  input logic [1:0] mode_q,
  input logic       bit_end,
  input logic       done_set
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (txd && shclk));

  p_start_low_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && mode_sel != 2'b00) |=> !txd);

  p_async_clk_high_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q != 2'b00) |-> shclk);

  p_hold_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_end) |=> $stable(txd));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    done_set |=> done_flag);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !done_clr) |=> done_flag);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (done_clr && !done_set) |=> !done_flag);

  p_accept_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy) |=> busy);

endmodule

bind multimode_serial_tx sptx_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_sel  (mode_sel),
  .wr_en     (wr_en),
  .done_clr  (done_clr),
  .txd       (txd),
  .shclk     (shclk),
  .busy      (busy),
  .done_flag (done_flag),
  .mode_q    (mode_q),
  .bit_end   (bit_end),
  .done_set  (done_set)
);

// File: tb/multimode_serial_tx_test.sv
module multimode_serial_tx_test;

  localparam int TICK_P = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       rate_fast = 1'b0;
  logic       rate_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ninth_bit = 1'b0;
  logic       done_clr = 1'b0;
  logic       txd, shclk, busy, done_flag;

  always #2 clk = ~clk;

  multimode_serial_tx uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .rate_fast(rate_fast),
    .rate_tick(rate_tick), .wr_en(wr_en), .wr_data(wr_data),
    .ninth_bit(ninth_bit), .done_clr(done_clr), .txd(txd), .shclk(shclk),
    .busy(busy), .done_flag(done_flag)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  mon_active = 0;

  typedef struct {
    logic [1:0] mode;
    logic [7:0] data;
    logic       ninth;
    logic       fast;
    bit         held;
  } item_t;

  item_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // Rate tick: one-cycle pulse every TICK_P cycles, changed just after the edge
  initial begin
    forever begin
      repeat (TICK_P - 1) @(posedge clk);
      #1 rate_tick = 1'b1;
      @(posedge clk);
      #1 rate_tick = 1'b0;
    end
  end

  // Monitor: pops the expected frame when busy rises, walks it bit by bit
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst || !busy) continue;
      mon_active = 1;
      if (exp_q.size() == 0) begin
        check(0, "R8", "unexpected frame", 1, 0);
        while (busy) @(negedge clk);
        mon_active = 0;
        continue;
      end
      begin
        item_t it;
        logic  eb [0:10];
        int    n, per;
        bit    ext, m0;
        string tb_tag, len_tag;
        it  = exp_q.pop_front();
        m0  = (it.mode == 2'b00);
        ext = (it.mode == 2'b01) || (it.mode == 2'b11);
        per = m0 ? 12 : (it.fast ? 32 : 64);
        if (m0) begin
          n = 8;
          for (int i = 0; i < 8; i++) eb[i] = it.data[i];
          tb_tag = "R2,R9"; len_tag = "R2";
        end else begin
          eb[0] = 1'b0;
          for (int i = 0; i < 8; i++) eb[i+1] = it.data[i];
          if (it.mode == 2'b01) begin
            n = 10; eb[9] = 1'b1;
          end else begin
            n = 11; eb[9] = it.ninth; eb[10] = 1'b1;
          end
          tb_tag = "R1,R9"; len_tag = ext ? "R4" : "R3";
        end
        for (int k = 0; k < n; k++) begin
          check(busy == 1'b1, "R8", $sformatf("busy in bit %0d", k), busy, 1);
          check(txd == eb[k], tb_tag, $sformatf("bit %0d value", k), txd, eb[k]);
          check(shclk == !m0, "R2", $sformatf("shclk at bit %0d start", k), shclk, !m0);
          if (!m0 && k == n-2) check(done_flag == 1'b0, "R6", "done before stop", done_flag, 0);
          if (!m0 && k == n-1) check(done_flag == 1'b1, "R6", "done at stop start", done_flag, 1);
          if (m0 && k == n-1)  check(done_flag == 1'b0, "R5", "done in last bit", done_flag, 0);
          if (ext) begin
            while (!rate_tick) @(negedge clk);
            check(txd == eb[k], "R4", $sformatf("bit %0d held to tick", k), txd, eb[k]);
            @(negedge clk);
          end else begin
            repeat (per/2) @(negedge clk);
            if (m0) check(shclk == 1'b1, "R2", $sformatf("shclk high half bit %0d", k), shclk, 1);
            repeat (per/2 - 1) @(negedge clk);
            check(txd == eb[k] && busy, len_tag, $sformatf("bit %0d last cycle", k), txd, eb[k]);
            @(negedge clk);
          end
        end
        check(busy == 1'b0, "R6", "busy after frame", busy, 0);
        check(txd == 1'b1 && shclk == 1'b1, "R1", "idle after frame", {txd, shclk}, 3);
        if (m0 || !it.held)
          check(done_flag == 1'b1, m0 ? "R5" : "R7", "done after frame", done_flag, 1);
        if (it.held) begin
          @(negedge clk);
          check(done_flag == 1'b0, "R7", "held clear after set", done_flag, 0);
        end
      end
      mon_active = 0;
    end
  end

  // Driver: clears the flag, pushes the expectation, writes, then a write to be ignored
  task automatic send(input logic [1:0] m, input logic [7:0] d, input logic nb,
                      input logic f, input bit held);
    item_t it;
    @(negedge clk);
    while (busy || mon_active || exp_q.size() != 0) @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    if (!held) done_clr = 1'b0;
    check(done_flag == 1'b0, "R7", "flag cleared by strobe", done_flag, 0);
    it.mode = m; it.data = d; it.ninth = nb; it.fast = f; it.held = held;
    exp_q.push_back(it);
    mode_sel = m; wr_data = d; ninth_bit = nb; rate_fast = f; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    mode_sel = m + 2'd1; rate_fast = ~f; ninth_bit = ~nb; wr_data = ~d;
    @(negedge clk);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    while (busy || mon_active) @(negedge clk);
    done_clr = 1'b0;
    repeat (3 * TICK_P) @(negedge clk);
    check(busy == 1'b0, "R8", "no frame from ignored write", busy, 0);
    if (!held) check(done_flag == 1'b1, "R7", "flag sticky", done_flag, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", "run timed out", 0, 1);
    summary();
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    check(txd == 1'b1, "R10", "txd after reset", txd, 1);
    check(shclk == 1'b1, "R10", "shclk after reset", shclk, 1);
    check(busy == 1'b0, "R10", "busy after reset", busy, 0);
    check(done_flag == 1'b0, "R10", "done after reset", done_flag, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    send(2'b01, 8'hA5, 1'b0, 1'b0, 0);
    send(2'b01, 8'h3C, 1'b1, 1'b1, 0);
    send(2'b11, 8'h5A, 1'b1, 1'b0, 0);
    send(2'b11, 8'hFF, 1'b0, 1'b1, 0);
    send(2'b10, 8'h81, 1'b1, 1'b1, 0);
    send(2'b10, 8'h0F, 1'b0, 1'b0, 0);
    send(2'b00, 8'hC3, 1'b0, 1'b0, 0);
    send(2'b00, 8'h01, 1'b1, 1'b1, 1);
    send(2'b01, 8'h00, 1'b0, 1'b0, 1);
    send(2'b10, 8'h6E, 1'b0, 1'b1, 1);

    repeat (10) @(negedge clk);
    summary();
    $finish;
  end

endmodule